// File: doc/BRIEF.md
# Hardware Deadline Timer Unit

This block gives a hardware thread deadlines as architectural state. It runs a free-running cycle counter and holds a small bank of deadline registers. A pipeline hands it one command per cycle. Each command carries an opcode, a deadline register index, an exception slot number and an offset. From these commands the block can load a deadline relative to the current time, or hold the thread until a deadline. It can also tell the pipeline whether a deadline has already gone by, or arm an exception slot that raises a request in the same cycle its deadline is reached.

The pipeline uses `stall` to freeze the thread and `branch_taken` to resolve a branch-on-expired query. It passes `exc_valid` and `exc_slot` to its exception logic. The block detects a late miss in two ways: by a query, or by a sticky per-register flag that an exact-execution command sets when its deadline is already gone. It detects a miss at once through armed slots.

Top module: `deadline_timer_unit`

## Requirements
- R1: After reset, `time_now` is 0 and then rises by exactly one every clock cycle. In the first cycle out of reset, `stall`, `branch_taken` and `exc_valid` are low and `miss_flags` is all zero.
- R2: Opcode 1 (set) loads deadline register `cmd_reg` with the `time_now` value of the command cycle plus `cmd_offset`. All deadlines reset to 0.
- R3: Opcode 2 (wait) drives `stall` high from the next cycle for as long as `time_now` is below the selected deadline. `stall` is low in the first cycle where `time_now` ≥ deadline. If the deadline has already been reached in the command cycle, there is no stall.
- R4: Opcode 3 (query) drives `branch_taken` high in the command cycle exactly when `time_now` ≥ the selected deadline, compared as unsigned values. `branch_taken` is low in every other cycle.
- R5: Opcode 4 (arm) binds slot `cmd_slot` to register `cmd_reg`. From the next cycle on, the slot raises `exc_valid` with `exc_slot` = slot number in the first cycle where `time_now` ≥ that deadline. It then disarms itself, so it raises one request per arm.
- R6: Opcode 5 (disarm) disarms slot `cmd_slot` and drops any request it still has pending, so that slot raises no later request.
- R7: Opcode 6 (exact) stalls in the same way as opcode 2. If the deadline has already been reached in the command cycle, it does not stall. Instead, from the next cycle it sets bit `cmd_reg` of `miss_flags`.
- R8: A bit of `miss_flags` stays set until an opcode 1 command to that register clears it.
- R9: When several slots request in the same cycle, `exc_slot` reports the lowest-numbered slot. The others stay pending and are reported one per cycle in rising slot order.
- R10: Re-arming a slot that still has a request pending drops that request. The slot then waits for the deadline of its new binding.
- R11: A command presented while `stall` is high has no effect. Opcodes 0 and 7 have no effect at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_valid | input | 1 | A command is presented this cycle |
| cmd_op | input | 3 | Opcode (0 none, 1 set, 2 wait, 3 query, 4 arm, 5 disarm, 6 exact) |
| cmd_reg | input | 2 | Deadline register index |
| cmd_slot | input | 2 | Exception slot number |
| cmd_offset | input | 64 | Offset added to the current time by opcode 1 |
| time_now | output | 64 | Free-running cycle counter |
| stall | output | 1 | Hold the thread |
| branch_taken | output | 1 | Query found the deadline reached |
| exc_valid | output | 1 | Exception request this cycle |
| exc_slot | output | 2 | Slot of the reported request |
| miss_flags | output | 4 | Sticky per-register miss from opcode 6 |

## Verification
The assertions assume that the pipeline presents commands only as single-cycle pulses on `cmd_valid`, with stable fields in that cycle. They also assume the 64-bit counter never wraps within a run, so every unsigned comparison keeps its meaning. The stimulus raises `cmd_valid` for exactly one cycle per command and uses small offsets, which keeps every deadline far below the counter's limit. It also presents commands on purpose while `stall` is high, so that the ignore rule is exercised rather than assumed away.

// File: rtl/dtu_pkg.sv
// Shared opcode encoding for the deadline timer unit.
// Assumes a 3-bit opcode field; codes 0 and 7 are no-operations.
package dtu_pkg;
    typedef enum logic [2:0] {
        OP_NONE   = 3'd0,
        OP_SET    = 3'd1,
        OP_WAIT   = 3'd2,
        OP_QUERY  = 3'd3,
        OP_ARM    = 3'd4,
        OP_DISARM = 3'd5,
        OP_EXACT  = 3'd6
    } dtu_op_e;
endpackage

// File: rtl/dtu_timebase.sv
// Free-running cycle counter, cleared by reset.
// Assumes the width is large enough that wrap never occurs in service.
module dtu_timebase #(
    parameter int TIME_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [TIME_W-1:0] now
);
    // Advance the time by one each cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) now <= '0;
        else        now <= now + 1'b1;
    end
endmodule

// File: rtl/dtu_deadline_bank.sv
// Bank of deadline registers with per-register reached flags and sticky
// miss flags. Assumes at most one load and one miss mark per cycle.
module dtu_deadline_bank #(
    parameter int TIME_W   = 64,
    parameter int NUM_REGS = 4,
    localparam int IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [TIME_W-1:0]   now,
    input  logic                load_en,
    input  logic [IDX_W-1:0]    load_idx,
    input  logic [TIME_W-1:0]   load_offset,
    input  logic                miss_en,
    input  logic [IDX_W-1:0]    miss_idx,
    output logic [NUM_REGS-1:0] reached,
    output logic [NUM_REGS-1:0] miss
);
    logic [TIME_W-1:0] deadline_q [NUM_REGS];

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
        // Hold one deadline, loaded relative to the current time.
        always_ff @(posedge clk) begin
            if (!rst_n)
                deadline_q[r] <= '0;
            else if (load_en && load_idx == IDX_W'(r))
                deadline_q[r] <= now + load_offset;
        end

        // Unsigned reached test: counter at or past the deadline.
        assign reached[r] = (now >= deadline_q[r]);

        // Sticky miss, set by a late exact command, cleared by a reload.
        always_ff @(posedge clk) begin
            if (!rst_n)
                miss[r] <= 1'b0;
            else if (load_en && load_idx == IDX_W'(r))
                miss[r] <= 1'b0;
            else if (miss_en && miss_idx == IDX_W'(r))
                miss[r] <= 1'b1;
        end
    end
endmodule

// File: rtl/dtu_exc_slots.sv
// Exception slots: each binds to a deadline register, fires once in the
// first cycle that deadline is reached, and queues behind lower slots.
// Assumes at most one arm or disarm per cycle.
module dtu_exc_slots #(
    parameter int NUM_REGS  = 4,
    parameter int NUM_SLOTS = 4,
    localparam int REG_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
    localparam int SLOT_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_REGS-1:0] reached,
    input  logic                arm_en,
    input  logic                disarm_en,
    input  logic [SLOT_W-1:0]   slot_idx,
    input  logic [REG_W-1:0]    reg_idx,
    output logic                req_valid,
    output logic [SLOT_W-1:0]   req_slot
);
    logic [NUM_SLOTS-1:0] armed_q, pending_q, touch, hit, req, grant;
    logic [REG_W-1:0]     bind_q [NUM_SLOTS];

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        // A command aimed at this slot overrides its expiry this cycle.
        assign touch[s] = (arm_en || disarm_en) && slot_idx == SLOT_W'(s);
        assign hit[s]   = armed_q[s] && reached[bind_q[s]] && !touch[s];
        assign req[s]   = (pending_q[s] || hit[s]) && !touch[s];

        // Slot state: binding, armed and pending bits.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                armed_q[s]   <= 1'b0;
                pending_q[s] <= 1'b0;
                bind_q[s]    <= '0;
            end else if (touch[s]) begin
                armed_q[s]   <= arm_en;
                pending_q[s] <= 1'b0;
                if (arm_en) bind_q[s] <= reg_idx;
            end else begin
                armed_q[s]   <= armed_q[s] && !hit[s];
                pending_q[s] <= req[s] && !grant[s];
            end
        end
    end

    // Fixed priority: lowest requesting slot wins.
    always_comb begin
        grant    = '0;
        req_slot = '0;
        for (int s = NUM_SLOTS - 1; s >= 0; s--) begin
            if (req[s]) begin
                grant    = '0;
                grant[s] = 1'b1;
                req_slot = SLOT_W'(s);
            end
        end
    end

    assign req_valid = |req;
endmodule

// File: rtl/deadline_timer_unit.sv
// Top of the deadline timer unit: decodes commands, owns the wait state
// that drives stall, and answers branch queries. Assumes the pipeline
// holds commands back while stall is high; any it presents are dropped.
module deadline_timer_unit
    import dtu_pkg::*;
#(
    parameter int TIME_W    = 64,
    parameter int NUM_REGS  = 4,
    parameter int NUM_SLOTS = 4,
    localparam int REG_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
    localparam int SLOT_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_valid,
    input  logic [2:0]          cmd_op,
    input  logic [REG_W-1:0]    cmd_reg,
    input  logic [SLOT_W-1:0]   cmd_slot,
    input  logic [TIME_W-1:0]   cmd_offset,
    output logic [TIME_W-1:0]   time_now,
    output logic                stall,
    output logic                branch_taken,
    output logic                exc_valid,
    output logic [SLOT_W-1:0]   exc_slot,
    output logic [NUM_REGS-1:0] miss_flags
);
    dtu_op_e             op;
    logic                fire, is_wait, sel_reached;
    logic                wait_q;
    logic [REG_W-1:0]    wait_reg_q;
    logic [NUM_REGS-1:0] reached;

    assign op          = dtu_op_e'(cmd_op);
    assign fire        = cmd_valid && !stall;
    assign is_wait     = (op == OP_WAIT) || (op == OP_EXACT);
    assign sel_reached = reached[cmd_reg];

    dtu_timebase #(.TIME_W(TIME_W)) u_time (
        .clk (clk),
        .rst_n (rst_n),
        .now (time_now)
    );

    dtu_deadline_bank #(.TIME_W(TIME_W), .NUM_REGS(NUM_REGS)) u_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .now         (time_now),
        .load_en     (fire && op == OP_SET),
        .load_idx    (cmd_reg),
        .load_offset (cmd_offset),
        .miss_en     (fire && op == OP_EXACT && sel_reached),
        .miss_idx    (cmd_reg),
        .reached     (reached),
        .miss        (miss_flags)
    );

    dtu_exc_slots #(.NUM_REGS(NUM_REGS), .NUM_SLOTS(NUM_SLOTS)) u_slots (
        .clk       (clk),
        .rst_n     (rst_n),
        .reached   (reached),
        .arm_en    (fire && op == OP_ARM),
        .disarm_en (fire && op == OP_DISARM),
        .slot_idx  (cmd_slot),
        .reg_idx   (cmd_reg),
        .req_valid (exc_valid),
        .req_slot  (exc_slot)
    );

    // Wait state: entered by a wait or exact command whose deadline is ahead.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wait_q     <= 1'b0;
            wait_reg_q <= '0;
        end else if (fire && is_wait && !sel_reached) begin
            wait_q     <= 1'b1;
            wait_reg_q <= cmd_reg;
        end else if (wait_q && reached[wait_reg_q]) begin
            wait_q     <= 1'b0;
        end
    end

    assign stall        = wait_q && !reached[wait_reg_q];
    assign branch_taken = fire && op == OP_QUERY && sel_reached;
endmodule

// File: rtl/deadline_timer_unit_chk.sv
// Checker for the deadline timer unit, bound to every instance of the top.
// Assumes single-cycle command pulses and no counter wrap.
module deadline_timer_unit_chk #(
    parameter int TIME_W    = 64,
    parameter int NUM_REGS  = 4,
    parameter int SLOT_W    = 2
) (
    input logic                clk,
    input logic                rst_n,
    input logic                cmd_valid,
    input logic [2:0]          cmd_op,
    input logic [TIME_W-1:0]   time_now,
    input logic                stall,
    input logic                branch_taken,
    input logic [NUM_REGS-1:0] miss_flags
);
    AST_TIME_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> time_now == $past(time_now) + 1'b1);  // R1
    AST_BRANCH_NEEDS_QUERY: assert property (@(posedge clk) disable iff (!rst_n)
        branch_taken |-> (cmd_valid && cmd_op == 3'd3));  // R4
    AST_STALL_FROM_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stall) |-> $past(cmd_valid && (cmd_op == 3'd2 || cmd_op == 3'd6)));  // R3
    AST_MISS_FROM_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
        ((miss_flags & ~$past(miss_flags)) != '0) |-> $past(cmd_valid && cmd_op == 3'd6 && !stall));  // R7
    AST_STALLED_CMD_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && cmd_valid) |=> miss_flags == $past(miss_flags));  // R11
    AST_NO_BRANCH_WHILE_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> !branch_taken);  // R11
endmodule

bind deadline_timer_unit deadline_timer_unit_chk #(
    .TIME_W(TIME_W), .NUM_REGS(NUM_REGS), .SLOT_W(SLOT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .time_now(time_now), .stall(stall), .branch_taken(branch_taken),
    .miss_flags(miss_flags)
);

// File: tb/deadline_timer_unit_tb.sv
`timescale 1ns/1ps
module deadline_timer_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_op = '0;
    logic [1:0]  cmd_reg = '0;
    logic [1:0]  cmd_slot = '0;
    logic [63:0] cmd_offset = '0;
    logic [63:0] time_now;
    logic        stall, branch_taken, exc_valid;
    logic [1:0]  exc_slot;
    logic [3:0]  miss_flags;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    deadline_timer_unit u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_reg(cmd_reg), .cmd_slot(cmd_slot), .cmd_offset(cmd_offset),
        .time_now(time_now), .stall(stall), .branch_taken(branch_taken),
        .exc_valid(exc_valid), .exc_slot(exc_slot), .miss_flags(miss_flags)
    );

    // Behavioural reference state.
    longint unsigned m_time;
    longint unsigned m_dl [4];
    bit              m_armed [4];
    bit              m_pend [4];
    int              m_bind [4];
    bit              m_miss [4];
    bit              m_wait;
    int              m_wreg;

    function automatic bit m_stall();
        return m_wait && (m_time < m_dl[m_wreg]);
    endfunction

    function automatic bit m_fire();
        return cmd_valid && !m_stall();
    endfunction

    function automatic bit m_touch(int s);
        return m_fire() && (cmd_op == 3'd4 || cmd_op == 3'd5) && int'(cmd_slot) == s;
    endfunction

    function automatic bit m_hit(int s);
        return m_armed[s] && (m_time >= m_dl[m_bind[s]]) && !m_touch(s);
    endfunction

    function automatic bit m_req(int s);
        return (m_pend[s] || m_hit(s)) && !m_touch(s);
    endfunction

    function automatic int m_winner();
        for (int s = 0; s < 4; s++) if (m_req(s)) return s;
        return -1;
    endfunction

    // Reference update on each rising edge, from the pre-edge state.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_time = 0; m_wait = 0; m_wreg = 0;
            for (int i = 0; i < 4; i++) begin
                m_dl[i] = 0; m_armed[i] = 0; m_pend[i] = 0; m_bind[i] = 0; m_miss[i] = 0;
            end
        end else begin
            automatic bit f    = m_fire();
            automatic int win  = m_winner();
            automatic int r    = int'(cmd_reg);
            automatic bit past = m_time >= m_dl[r];
            automatic bit hits [4];
            automatic bit reqs [4];
            automatic bit tch [4];
            for (int s = 0; s < 4; s++) begin
                hits[s] = m_hit(s); reqs[s] = m_req(s); tch[s] = m_touch(s);
            end
            if (f && (cmd_op == 3'd2 || cmd_op == 3'd6) && !past) begin
                m_wait = 1; m_wreg = r;
            end else if (m_wait && m_time >= m_dl[m_wreg]) begin
                m_wait = 0;
            end
            if (f && cmd_op == 3'd6 && past) m_miss[r] = 1;
            for (int s = 0; s < 4; s++) begin
                if (tch[s]) begin
                    m_armed[s] = (cmd_op == 3'd4);
                    m_pend[s]  = 0;
                    if (cmd_op == 3'd4) m_bind[s] = r;
                end else begin
                    if (hits[s]) m_armed[s] = 0;
                    m_pend[s] = reqs[s] && (s != win);
                end
            end
            if (f && cmd_op == 3'd1) begin
                m_dl[r] = m_time + cmd_offset;
                m_miss[r] = 0;
            end
            m_time = m_time + 1;
        end
    end

    task automatic check(string tag, longint unsigned act, longint unsigned exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at t=%0t", tag, act, exp, $time);
        end
    endtask

    // Compare every output at the falling edge.
    always @(negedge clk) begin
        automatic int w = m_winner();
        automatic logic [3:0] mm = {m_miss[3], m_miss[2], m_miss[1], m_miss[0]};
        cycles++;
        check("R1 time_now", time_now, m_time);
        check("R3 R7 R11 stall", stall, m_stall());
        check("R2 R4 branch_taken", branch_taken,
              m_fire() && cmd_op == 3'd3 && m_time >= m_dl[cmd_reg]);
        check("R5 R6 R10 exc_valid", exc_valid, w >= 0);
        if (w >= 0) check("R9 exc_slot", exc_slot, w);
        check("R7 R8 miss_flags", miss_flags, mm);
        if (cycles > 20000) begin
            fails++;
            $display("FAIL watchdog: actual %0d expected below 20000 cycles", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic idle(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic cmd(logic [2:0] op, int r, int s, longint unsigned off);
        @(posedge clk); #1;
        cmd_valid = 1; cmd_op = op; cmd_reg = r[1:0]; cmd_slot = s[1:0]; cmd_offset = off;
        @(posedge clk); #1;
        cmd_valid = 0; cmd_op = 0; cmd_offset = 0;
    endtask

    initial begin
        idle(3);
        rst_n = 1;
        idle(3);
        // R2 R4: load and query before and after the deadline.
        cmd(3'd1, 0, 0, 30);
        cmd(3'd3, 0, 0, 0);
        // R3 R11: wait, and offer commands while stalled.
        cmd(3'd2, 0, 0, 0);
        cmd(3'd1, 1, 0, 5);
        cmd(3'd6, 2, 0, 0);
        while (stall) idle(1);
        cmd(3'd3, 0, 0, 0);
        // R3: wait on an expired deadline does not stall.
        cmd(3'd1, 1, 0, 4);
        idle(10);
        cmd(3'd2, 1, 0, 0);
        // R11: no-op codes.
        cmd(3'd0, 1, 0, 99);
        cmd(3'd7, 1, 0, 99);
        // R7 R8: exact on time, then exact late, then reload clears.
        cmd(3'd1, 2, 0, 12);
        cmd(3'd6, 2, 0, 0);
        while (stall) idle(1);
        cmd(3'd6, 2, 0, 0);
        idle(3);
        cmd(3'd1, 2, 0, 40);
        // R5 R9: three slots share one deadline, one fires at once.
        cmd(3'd1, 3, 0, 20);
        cmd(3'd4, 3, 2, 0);
        cmd(3'd4, 3, 1, 0);
        cmd(3'd4, 3, 3, 0);
        cmd(3'd4, 1, 0, 0);
        idle(30);
        // R6: disarm before expiry.
        cmd(3'd1, 0, 0, 15);
        cmd(3'd4, 0, 0, 0);
        cmd(3'd5, 0, 0, 0);
        idle(25);
        // R10: re-arm a pending slot onto a far deadline.
        cmd(3'd1, 0, 0, 500);
        cmd(3'd1, 3, 0, 8);
        cmd(3'd4, 3, 1, 0);
        cmd(3'd4, 3, 2, 0);
        cmd(3'd4, 3, 3, 0);
        while (!exc_valid) idle(1);
        @(negedge clk); #1;
        cmd_valid = 1; cmd_op = 3'd4; cmd_reg = 2'd0; cmd_slot = 2'd3;
        @(posedge clk); #1;
        cmd_valid = 0; cmd_op = 0;
        idle(10);
        // R6: disarm drops a pending request.
        cmd(3'd1, 3, 0, 6);
        cmd(3'd4, 3, 0, 0);
        cmd(3'd4, 3, 1, 0);
        while (!exc_valid) idle(1);
        @(negedge clk); #1;
        cmd_valid = 1; cmd_op = 3'd5; cmd_slot = 2'd1;
        @(posedge clk); #1;
        cmd_valid = 0; cmd_op = 0;
        idle(10);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule